// File: doc/BRIEF.md
# Trigger Veto and Input Snapshot Unit

This block sits between a host and a 16-bit digital I/O panel that gates event triggers. The host writes a 16-bit output register. Some of its bits pick the trigger type, and the lowest bit is a self-clearing command that lifts the trigger veto. Output bits 1 to 10 are looped back into the matching bits of the 16-bit input register. Because of this, the trigger settings in force are recorded together with each event.

Bit 15 of the input register carries the event trigger. A rising edge on it is accepted only while the veto is down and no earlier record is still waiting to be sent. On acceptance the block raises the veto, freezes the input register, the running cycle count and an external latch word, and then streams a three-word event header over a valid/ready handshake. Trigger edges that arrive while the block cannot accept them are dropped and counted.

Top module: `trig_veto_dio`

## Requirements
- R1: After reset the output register, the veto flag, the rejected-edge count and the header valid flag are all zero.
- R2: A host write loads bits 15..1 of the output register from the write data. Bit 0 always reads back as 0.
- R3: A host write with data bit 0 set drops the veto on the next clock edge. A write with data bit 0 clear leaves the veto unchanged.
- R4: A 0-to-1 change of input bit 15, seen while the veto is down and no header is pending, is accepted. The veto reads 1 from the following cycle on.
- R5: A 0-to-1 change of input bit 15 that is not accepted, because the veto is up or a header is pending, starts no header. It adds one to the 16-bit rejected-edge count.
- R6: Input bit 15 held high produces no further trigger.
- R7: Header valid rises in the cycle after acceptance. Word 1 is the input register captured at the accepting edge, zero-extended to 32 bits. In that input register, bits 10..1 come from the output register and the other bits come from the panel inputs.
- R8: Word 0 is a free-running 32-bit count of clock edges since reset release, sampled just before the accepting edge.
- R9: Word 2 is the external latch word sampled at the accepting edge. Later changes to it do not alter the header.
- R10: The header words leave in the order 0, 1, 2, one per valid-and-ready cycle. The current word is held while ready is low. The last flag marks word 2, and valid falls after word 2 is taken.
- R11: A veto-clearing write in the same cycle as a trigger edge lets that edge be accepted when no header is pending. The veto then stays up.
- R12: A write in the same cycle as an accepted edge does not reach the snapshot. The loopback bits hold the output register as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_wr_i | input | 1 | Host write strobe for the output register |
| out_wdata_i | input | 16 | Host write data; bit 0 is the veto-clear command |
| panel_in_i | input | 16 | Panel input bits; bit 15 is the trigger |
| latch_word_i | input | 32 | External latch word captured on acceptance |
| hdr_ready_i | input | 1 | Header sink ready |
| out_reg_o | output | 16 | Output register readback |
| in_reg_o | output | 16 | Live input register, loopback bits merged |
| veto_o | output | 1 | Trigger veto flag |
| rej_cnt_o | output | 16 | Rejected trigger edge count |
| hdr_valid_o | output | 1 | Header word valid |
| hdr_data_o | output | 32 | Header word |
| hdr_last_o | output | 1 | Marks the third header word |

## Verification
Two cases can fall on a single clock edge: a host veto clear together with a trigger edge, and a host write together with snapshot capture. The bench drives both the write strobe and the rising trigger bit on the same falling edge, so they meet at one rising edge. It then expects three things: the trigger is accepted, the veto stays up, and the captured loopback bits show the output register from before the write. Random events with random write data, stalls and rejected edges repeat these collisions against a bench model of the output register.

// File: rtl/trig_dio_pkg.sv
package trig_dio_pkg;
  localparam int unsigned IO_W   = 16;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [1:0] {
    W_TIME  = 2'd0,
    W_INREG = 2'd1,
    W_LATCH = 2'd2
  } hdr_word_e;
endpackage

// File: rtl/dio_regs.sv
module dio_regs #(
  parameter int unsigned IO_W    = 16,
  parameter int unsigned CLR_BIT = 0,
  parameter int unsigned LB_LO   = 1,
  parameter int unsigned LB_HI   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [IO_W-1:0] wdata_i,
  input  logic [IO_W-1:0] panel_i,
  output logic [IO_W-1:0] out_q_o,
  output logic [IO_W-1:0] in_word_o,
  output logic            clr_o
);
  function automatic logic [IO_W-1:0] lb_mask_f();
    logic [IO_W-1:0] m;
    m = '0;
    for (int b = 0; b < int'(IO_W); b++)
      if (b >= int'(LB_LO) && b <= int'(LB_HI)) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [IO_W-1:0] LB_MASK = lb_mask_f();
  localparam logic [IO_W-1:0] WR_MASK = ~(IO_W'(1) << CLR_BIT);

  logic [IO_W-1:0] out_q;

  // clear bit never stored: it acts as a pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_q <= '0;
    else if (wr_i) out_q <= wdata_i & WR_MASK;
  end

  assign clr_o     = wr_i & wdata_i[CLR_BIT];
  assign in_word_o = (panel_i & ~LB_MASK) | (out_q & LB_MASK);
  assign out_q_o   = out_q;

  a_r2_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (out_q_o == ($past(wdata_i) & WR_MASK)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(out_q_o));
endmodule

// File: rtl/veto_ctrl.sv
module veto_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic             busy_i,
  output logic             accept_o,
  output logic             veto_o,
  output logic [CNT_W-1:0] rej_cnt_o
);
  logic             trig_prev_q, veto_q;
  logic [CNT_W-1:0] rej_q;
  logic             edge_s, open_s, reject_s;

  assign edge_s   = trig_i & ~trig_prev_q;
  // a clear in the same cycle opens the gate for this edge
  assign open_s   = ~veto_q | clr_i;
  assign accept_o = edge_s & open_s & ~busy_i;
  assign reject_s = edge_s & ~accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_prev_q <= 1'b1;  // a line already high at reset is not an edge
      veto_q      <= 1'b0;
      rej_q       <= '0;
    end else begin
      trig_prev_q <= trig_i;
      if (accept_o)   veto_q <= 1'b1;
      else if (clr_i) veto_q <= 1'b0;
      if (reject_s)   rej_q <= rej_q + 1'b1;
    end
  end

  assign veto_o    = veto_q;
  assign rej_cnt_o = rej_q;

  a_r4_veto_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> veto_o);

  a_r3_clear_drops_veto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !accept_o) |=> !veto_o);

  a_r5_reject_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_s && !accept_o) |=> (rej_cnt_o == $past(rej_cnt_o) + 1'b1));

  a_r6_level_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trig_i) && trig_i) |-> !accept_o);
endmodule

// File: rtl/hdr_emit.sv
module hdr_emit
  import trig_dio_pkg::*;
#(
  parameter int unsigned IO_W   = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic [IO_W-1:0]   inword_i,
  input  logic [WORD_W-1:0] latch_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              last_o,
  output logic              busy_o
);
  localparam int unsigned PAD_W = WORD_W - IO_W;

  logic [WORD_W-1:0] time_q, latch_q;
  logic [IO_W-1:0]   in_q;
  hdr_word_e         idx_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      latch_q <= '0;
      in_q    <= '0;
      idx_q   <= W_TIME;
      valid_q <= 1'b0;
    end else if (accept_i) begin
      time_q  <= time_i;
      latch_q <= latch_i;
      in_q    <= inword_i;
      idx_q   <= W_TIME;
      valid_q <= 1'b1;
    end else if (valid_q && ready_i) begin
      case (idx_q)
        W_TIME:  idx_q <= W_INREG;
        W_INREG: idx_q <= W_LATCH;
        default: begin
          idx_q   <= W_TIME;
          valid_q <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      W_TIME:  data_o = time_q;
      W_INREG: data_o = {{PAD_W{1'b0}}, in_q};
      default: data_o = latch_q;
    endcase
  end

  assign valid_o = valid_q;
  assign last_o  = valid_q && (idx_q == W_LATCH);
  assign busy_o  = valid_q;

  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (valid_o && idx_q == W_TIME));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !accept_i) |=> (valid_o && $stable(data_o) && $stable(idx_q)));

  a_r10_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o && !accept_i) |=> !valid_o);
endmodule

// File: rtl/trig_veto_dio.sv
module trig_veto_dio
  import trig_dio_pkg::*;
#(
  parameter int unsigned P_IO_W    = IO_W,
  parameter int unsigned P_WORD_W  = WORD_W,
  parameter int unsigned P_CNT_W   = CNT_W,
  parameter int unsigned CLR_BIT   = 0,
  parameter int unsigned TRIG_BIT  = 15,
  parameter int unsigned LB_LO     = 1,
  parameter int unsigned LB_HI     = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                out_wr_i,
  input  logic [P_IO_W-1:0]   out_wdata_i,
  input  logic [P_IO_W-1:0]   panel_in_i,
  input  logic [P_WORD_W-1:0] latch_word_i,
  input  logic                hdr_ready_i,
  output logic [P_IO_W-1:0]   out_reg_o,
  output logic [P_IO_W-1:0]   in_reg_o,
  output logic                veto_o,
  output logic [P_CNT_W-1:0]  rej_cnt_o,
  output logic                hdr_valid_o,
  output logic [P_WORD_W-1:0] hdr_data_o,
  output logic                hdr_last_o
);
  logic [P_IO_W-1:0]   in_word;
  logic                clr_s, accept_s, busy_s;
  logic [P_WORD_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_q + 1'b1;
  end

  dio_regs #(
    .IO_W(P_IO_W), .CLR_BIT(CLR_BIT), .LB_LO(LB_LO), .LB_HI(LB_HI)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (out_wr_i),
    .wdata_i  (out_wdata_i),
    .panel_i  (panel_in_i),
    .out_q_o  (out_reg_o),
    .in_word_o(in_word),
    .clr_o    (clr_s)
  );

  veto_ctrl #(.CNT_W(P_CNT_W)) u_veto (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (in_word[TRIG_BIT]),
    .clr_i    (clr_s),
    .busy_i   (busy_s),
    .accept_o (accept_s),
    .veto_o   (veto_o),
    .rej_cnt_o(rej_cnt_o)
  );

  hdr_emit #(.IO_W(P_IO_W), .WORD_W(P_WORD_W)) u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept_s),
    .time_i  (time_q),
    .inword_i(in_word),
    .latch_i (latch_word_i),
    .ready_i (hdr_ready_i),
    .valid_o (hdr_valid_o),
    .data_o  (hdr_data_o),
    .last_o  (hdr_last_o),
    .busy_o  (busy_s)
  );

  assign in_reg_o = in_word;

  a_r5_no_accept_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> (hdr_valid_o || !$past(hdr_last_o && !hdr_ready_i)));

  a_r11_veto_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_s && clr_s) |=> (veto_o && hdr_valid_o));
endmodule

// File: tb/trig_veto_dio_tb.sv
module trig_veto_dio_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        out_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] panel = '0;
  logic [31:0] latch = '0;
  logic        hdr_ready = 1'b0;
  logic [15:0] out_reg, in_reg, rej_cnt;
  logic        veto, hdr_valid, hdr_last;
  logic [31:0] hdr_data;

  logic [31:0] tb_cyc;
  logic [15:0] out_model = '0;
  logic [15:0] rej_model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cyc <= '0;
    else        tb_cyc <= tb_cyc + 1;

  trig_veto_dio u_dut (
    .clk_i(clk), .rst_ni(rst_n), .out_wr_i(out_wr), .out_wdata_i(wdata),
    .panel_in_i(panel), .latch_word_i(latch), .hdr_ready_i(hdr_ready),
    .out_reg_o(out_reg), .in_reg_o(in_reg), .veto_o(veto), .rej_cnt_o(rej_cnt),
    .hdr_valid_o(hdr_valid), .hdr_data_o(hdr_data), .hdr_last_o(hdr_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_in(input logic [15:0] p, input logic [15:0] o);
    logic [15:0] r;
    r = p;
    r[10:1] = o[10:1];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d);
    out_wr = 1'b1;
    wdata  = d;
    step();
    out_wr = 1'b0;
    out_model = {d[15:1], 1'b0};
  endtask

  task automatic pulse_reject();
    panel[15] = 1'b0;
    step();
    panel[15] = 1'b1;
    step();
    rej_model++;
  endtask

  // Caller guarantees acceptance: veto down, or wr_same with bit 0 set.
  task automatic fire_event(input logic [15:0] p, input logic [31:0] lw,
                            input bit wr_same, input logic [15:0] wd,
                            input bit busy_probe, input int stall);
    logic [31:0] exp_w [3];
    int w;
    bit exp_veto;
    panel = p & 16'h7fff;
    step();
    panel[15] = 1'b1;
    latch = lw;
    exp_w[0] = tb_cyc;                       // R8
    exp_w[1] = {16'h0, exp_in(panel, out_model)};  // R7, R12
    exp_w[2] = lw;                           // R9
    if (wr_same) begin
      out_wr = 1'b1;
      wdata  = wd;
    end
    step();
    out_wr = 1'b0;
    if (wr_same) out_model = {wd[15:1], 1'b0};
    latch = ~lw;
    hdr_ready = 1'b0;
    chk("R7 valid after accept", {31'b0, hdr_valid}, 32'd1);
    chk("R4 veto set", {31'b0, veto}, 32'd1);
    if (wr_same) chk("R12 out reg after same-cycle write", {16'h0, out_reg}, {16'h0, out_model});
    exp_veto = 1'b1;
    if (busy_probe) begin
      host_write(out_model | 16'h0001);
      chk("R3 clear while pending", {31'b0, veto}, 32'd0);
      pulse_reject();
      chk("R5 busy reject count", {16'h0, rej_cnt}, {16'h0, rej_model});
      chk("R5 veto stays clear", {31'b0, veto}, 32'd0);
      exp_veto = 1'b0;
    end
    w = 0;
    for (int g = 0; g < 2000 && w < 3; g++) begin
      hdr_ready = ($urandom_range(0, 99) >= stall);
      if (hdr_ready && hdr_valid) begin
        chk($sformatf("R10 word %0d data", w), hdr_data, exp_w[w]);
        chk($sformatf("R10 word %0d last", w), {31'b0, hdr_last}, {31'b0, w == 2});
        w++;
      end else if (!hdr_valid) begin
        chk("R10 valid held", 32'd0, 32'd1);
      end
      step();
    end
    hdr_ready = 1'b0;
    chk("R10 all words taken", w, 32'd3);
    chk("R10 valid falls", {31'b0, hdr_valid}, 32'd0);
    step();
    step();
    chk("R6 held level no trigger", {31'b0, hdr_valid}, 32'd0);
    chk("R6 no reject count", {16'h0, rej_cnt}, {16'h0, rej_model});
    chk("R4 veto after event", {31'b0, veto}, {31'b0, exp_veto});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out reg", {16'h0, out_reg}, 32'd0);
    chk("R1 veto", {31'b0, veto}, 32'd0);
    chk("R1 reject count", {16'h0, rej_cnt}, 32'd0);
    chk("R1 valid", {31'b0, hdr_valid}, 32'd0);

    host_write(16'hA5A5);
    chk("R2 bit0 reads zero", {16'h0, out_reg}, 32'h0000A5A4);
    panel = 16'h0F0F;
    @(negedge clk);
    chk("R7 loopback live", {16'h0, in_reg}, {16'h0, exp_in(16'h0F0F, out_model)});

    fire_event(16'h1234, 32'hDEADBEEF, 0, 16'h0, 0, 30);

    pulse_reject();
    pulse_reject();
    chk("R5 veto reject count", {16'h0, rej_cnt}, {16'h0, rej_model});
    chk("R5 no header on reject", {31'b0, hdr_valid}, 32'd0);

    host_write(out_model);
    chk("R3 write bit0 clear keeps veto", {31'b0, veto}, 32'd1);
    host_write(out_model | 16'h0001);
    chk("R3 write bit0 set drops veto", {31'b0, veto}, 32'd0);

    fire_event(16'h4321, 32'h0BADF00D, 0, 16'h0, 1, 50);

    // veto is down after the probe; raise it with a plain event
    fire_event(16'h0001, 32'h11111111, 0, 16'h0, 0, 0);
    chk("R11 veto up before collision", {31'b0, veto}, 32'd1);
    fire_event(16'h7FFE, 32'h22222222, 1, 16'h07F9, 0, 20);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] wd;
      host_write(16'($urandom) | 16'h0001);
      wd = 16'($urandom);
      fire_event(16'($urandom), $urandom, $urandom_range(0, 1), wd,
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 70));
      if (veto) begin
        for (int k = 0; k < int'($urandom_range(0, 2)); k++) pulse_reject();
        chk("R5 random reject count", {16'h0, rej_cnt}, {16'h0, rej_model});
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule